// File: doc/BRIEF.md
# Serial Receive Status Timing Unit

This block receives asynchronous serial characters on a single line. A free-running enable, `tick_16x`, runs at sixteen times the bit rate. After a two-stage synchronizer, the receiver finds the falling edge of a start bit and confirms it at the middle of the bit. It then samples the data bits least significant first, an optional parity bit, and the first stop bit. Each finished character is delivered to a receive buffer register. The block raises data-ready, overrun, parity, framing and break flags with exact timing. A single receive interrupt request follows these flags.

The block has a buffered mode, selected by `fifo_mode`. In this mode the data-ready, overrun and first-byte error indications come three enables later than in direct mode. The buffer store is modelled as one holding entry behind the visible receive buffer register. A character that waits in the holding entry shows its error flags only when the CPU ends its read of the receive buffer. Each read strobe (`rbr_rd` for the receive buffer, `lsr_rd` for status) takes effect in the clock after it is released.

Top module: `uart_rx_status`

## Requirements
- R1: A start bit is accepted only if the synchronized line is still low 8 enables after the falling edge is seen. A low pulse that is shorter than this produces no character and leaves `data_ready` at 0.
- R2: Data bits are sampled least significant bit first, every 16 enables after the confirmed start. `rx_data` shows the received byte.
- R3: In direct mode (`fifo_mode`=0), `data_ready` and the error flags are set on the enable that samples the first stop bit. With `tick_16x` held high and default parameters, this is the 171st rising clock edge after the line is driven low.
- R4: `rx_irq` goes high one enable after the status flags become non-zero. It falls one enable after they all clear.
- R5: In buffered mode (`fifo_mode`=1), `data_ready` and `overrun_err` are set 3 enables later than in direct mode. So are the parity, framing and break flags of a character that enters an empty receive buffer.
- R6: In buffered mode, a character that completes while the receive buffer is full moves to the holding entry, and its error flags are not shown. In the clock after `rbr_rd` falls, the held character moves into `rx_data` and its error flags appear in `parity_err`/`framing_err`/`break_det`, while `data_ready` stays 1.
- R7: The parity bit uses even parity by default (the data bits plus the parity bit hold an even number of ones). A mismatch sets `parity_err`.
- R8: A stop bit sampled as 0 sets `framing_err`.
- R9: A frame that is 0 from start through stop sets both `break_det` and `framing_err`. The receiver then waits for the line to return high before it looks for another start bit.
- R10: `overrun_err` is set when a character completes while no space is free. In direct mode, no space is free when `data_ready` is set. In buffered mode, no space is free when both the receive buffer and the holding entry are full. The newest character replaces the one in the last stage (`rx_data` in direct mode, the holding entry in buffered mode).
- R11: In the clock after `rbr_rd` falls, `data_ready` is cleared when no held character is waiting.
- R12: In the clock after `lsr_rd` falls, `overrun_err`, `parity_err`, `framing_err` and `break_det` are cleared. `data_ready` and `rx_data` are not changed.
- R13: After reset, all flags, `rx_irq` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_16x | input | 1 | Enable at sixteen times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| fifo_mode | input | 1 | 1 selects buffered mode with delayed status |
| rbr_rd | input | 1 | Receive buffer read strobe, acted on when it falls |
| lsr_rd | input | 1 | Status read strobe, acted on when it falls |
| rx_data | output | DATA_BITS | Receive buffer register |
| data_ready | output | 1 | A character waits in the receive buffer |
| overrun_err | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity flag |
| framing_err | output | 1 | Sticky framing flag |
| break_det | output | 1 | Sticky break flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
With `tick_16x` held high, each result is due at a fixed clock count after the bench drives the line low. `data_ready` in direct mode is due after 171 edges: two synchronizer stages, one edge-detection edge, 8 enables to the start midpoint, and 160 enables to the stop sample. In buffered mode the same flags are due after 174 edges, and `rx_irq` follows either one edge later. A read strobe takes effect in the clock after it falls. Every timing check samples the output on the falling clock edge one cycle before its due edge and again on the falling edge just after it. It expects the old value first and the new value second, so an early or a late update is caught.

// File: rtl/urs_pkg.sv
// Shared types for the serial receive status unit.
// Assumes: one frame is start, data, optional parity and one stop bit.
package urs_pkg;

    // Receiver frame position.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITHI
    } rx_state_t;

    // Error flags that belong to one received character.
    typedef struct packed {
        logic perr;
        logic ferr;
        logic brk;
    } err_t;

endpackage

// File: rtl/urs_sync.sv
// Synchronizer for the asynchronous serial line.
// Resets to the idle (high) level so that reset is never seen as a start bit.
// Assumes: STAGES >= 2.
module urs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    // Shift the line through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/urs_deframer.sv
// Serial deframer. It finds the start edge, confirms it at mid-bit, samples the
// data, parity and stop bits, and gives a one-clock strobe on the first stop
// sample. The byte and its error flags are valid with that strobe.
// Assumes: rx_s is synchronized; tick is the oversampling enable.
module urs_deframer
    import urs_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_s,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output err_t                 errs
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] TOP_BIT = BW'(DATA_BITS - 1);
    localparam logic ODD_L = (PARITY_ODD != 0);

    rx_state_t            state;
    logic [CW-1:0]        cnt;
    logic [BW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_q;
    logic                 seen_one;

    // Frame sequencer: runs on every oversampling enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
            seen_one <= 1'b0;
        end else if (tick) begin
            case (state)
                ST_IDLE: begin
                    if (!rx_s) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                end
                ST_START: begin
                    if (cnt == MID) begin
                        cnt <= '0;
                        if (!rx_s) begin
                            state    <= ST_DATA;
                            bit_idx  <= '0;
                            seen_one <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == LAST) begin
                        cnt      <= '0;
                        shreg    <= {rx_s, shreg[DATA_BITS-1:1]};
                        seen_one <= seen_one | rx_s;
                        if (bit_idx == TOP_BIT)
                            state <= (PARITY_EN != 0) ? ST_PAR : ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (cnt == LAST) begin
                        cnt      <= '0;
                        par_q    <= rx_s;
                        seen_one <= seen_one | rx_s;
                        state    <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        state <= rx_s ? ST_IDLE : ST_WAITHI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAITHI: begin
                    if (rx_s) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe and per-character flags on the first stop-bit sample.
    always_comb begin
        done      = tick && (state == ST_STOP) && (cnt == LAST);
        data      = shreg;
        errs.ferr = !rx_s;
        errs.brk  = !rx_s && !seen_one;
        errs.perr = (PARITY_EN != 0) ? ((^shreg) ^ par_q ^ ODD_L) : 1'b0;
    end

    // R3
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/urs_delay.sv
// Delay for the buffered-mode status path. It holds one finished character
// and releases it DELAY enables later as a one-clock strobe.
// Assumes: characters arrive far more than DELAY enables apart.
module urs_delay
    import urs_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int DELAY     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 in_valid,
    input  logic [DATA_BITS-1:0] in_data,
    input  err_t                 in_err,
    output logic                 out_valid,
    output logic [DATA_BITS-1:0] out_data,
    output err_t                 out_err
);
    generate
        if (DELAY == 0) begin : g_pass
            assign out_valid = in_valid;
            assign out_data  = in_data;
            assign out_err   = in_err;
        end else begin : g_hold
            localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
            localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

            logic                 pend;
            logic [CW-1:0]        cnt;
            logic [DATA_BITS-1:0] data_q;
            err_t                 err_q;

            // Capture a character and count enables until release.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend   <= 1'b0;
                    cnt    <= '0;
                    data_q <= '0;
                    err_q  <= '0;
                end else if (in_valid) begin
                    pend   <= 1'b1;
                    cnt    <= '0;
                    data_q <= in_data;
                    err_q  <= in_err;
                end else if (tick && pend) begin
                    if (cnt == LAST) pend <= 1'b0;
                    else             cnt  <= cnt + 1'b1;
                end
            end

            assign out_valid = pend && tick && (cnt == LAST);
            assign out_data  = data_q;
            assign out_err   = err_q;
        end
    endgenerate
endmodule

// File: rtl/urs_status.sv
// Receive buffer, one holding entry, sticky line flags and the interrupt request.
// Read strobes take effect in the clock after they fall. In one clock, a status
// read clears first, then a buffer read promotes, then a new character lands.
// Assumes: commit is a one-clock strobe; commit_fifo marks the delayed path.
module urs_status
    import urs_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 fifo_mode,
    input  logic                 commit,
    input  logic                 commit_fifo,
    input  logic [DATA_BITS-1:0] commit_data,
    input  err_t                 commit_err,
    input  logic                 rbr_rd,
    input  logic                 lsr_rd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_ready,
    output logic                 overrun_err,
    output logic                 parity_err,
    output logic                 framing_err,
    output logic                 break_det,
    output logic                 rx_irq
);
    logic                 rd_q, lsr_q;
    logic                 hold_v;
    logic [DATA_BITS-1:0] hold_data;
    err_t                 hold_err;

    logic                 rd_end, lsr_end;
    logic [DATA_BITS-1:0] top_n, hold_data_n;
    logic                 dr_n, oe_n, pe_n, fe_n, bi_n, hold_v_n;
    err_t                 hold_err_n;

    assign rd_end  = rd_q && !rbr_rd;
    assign lsr_end = lsr_q && !lsr_rd;

    // Next state of the buffers and flags.
    always_comb begin
        top_n       = rx_data;
        dr_n        = data_ready;
        oe_n        = overrun_err;
        pe_n        = parity_err;
        fe_n        = framing_err;
        bi_n        = break_det;
        hold_v_n    = hold_v;
        hold_data_n = hold_data;
        hold_err_n  = hold_err;

        if (lsr_end) begin
            oe_n = 1'b0;
            pe_n = 1'b0;
            fe_n = 1'b0;
            bi_n = 1'b0;
        end

        if (rd_end) begin
            if (fifo_mode && hold_v) begin
                top_n    = hold_data;
                pe_n     = pe_n | hold_err.perr;
                fe_n     = fe_n | hold_err.ferr;
                bi_n     = bi_n | hold_err.brk;
                hold_v_n = 1'b0;
            end else begin
                dr_n = 1'b0;
            end
        end

        if (commit) begin
            if (commit_fifo && dr_n) begin
                hold_data_n = commit_data;
                hold_err_n  = commit_err;
                if (hold_v_n) oe_n = 1'b1;
                hold_v_n = 1'b1;
            end else begin
                if (dr_n) oe_n = 1'b1;
                top_n = commit_data;
                dr_n  = 1'b1;
                pe_n  = pe_n | commit_err.perr;
                fe_n  = fe_n | commit_err.ferr;
                bi_n  = bi_n | commit_err.brk;
            end
        end

        if (!fifo_mode) hold_v_n = 1'b0;
    end

    // Register buffers, flags and the strobe history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            data_ready  <= 1'b0;
            overrun_err <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            break_det   <= 1'b0;
            hold_v      <= 1'b0;
            hold_data   <= '0;
            hold_err    <= '0;
            rd_q        <= 1'b0;
            lsr_q       <= 1'b0;
        end else begin
            rx_data     <= top_n;
            data_ready  <= dr_n;
            overrun_err <= oe_n;
            parity_err  <= pe_n;
            framing_err <= fe_n;
            break_det   <= bi_n;
            hold_v      <= hold_v_n;
            hold_data   <= hold_data_n;
            hold_err    <= hold_err_n;
            rd_q        <= rbr_rd;
            lsr_q       <= lsr_rd;
        end
    end

    // Interrupt request follows the flags one enable later.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_irq <= 1'b0;
        else if (tick) rx_irq <= data_ready | overrun_err | parity_err | framing_err | break_det;
    end

    // R4
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(data_ready | overrun_err | parity_err | framing_err | break_det));

    // R6
    hold_needs_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_v |-> data_ready);

    // R9
    break_has_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |-> framing_err);

    // R10
    overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $past(data_ready));
endmodule

// File: rtl/uart_rx_status.sv
// Top of the serial receive status unit. It connects the synchronizer, the
// deframer, the buffered-mode delay and the status registers. In direct mode,
// a finished character reaches the status registers on the stop sample. In
// buffered mode it reaches them FIFO_DELAY enables later.
// Assumes: tick_16x runs at OVERSAMPLE times the bit rate.
module uart_rx_status
    import urs_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int PARITY_EN   = 1,
    parameter int PARITY_ODD  = 0,
    parameter int FIFO_DELAY  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_16x,
    input  logic                 rx_in,
    input  logic                 fifo_mode,
    input  logic                 rbr_rd,
    input  logic                 lsr_rd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_ready,
    output logic                 overrun_err,
    output logic                 parity_err,
    output logic                 framing_err,
    output logic                 break_det,
    output logic                 rx_irq
);
    logic                 rx_s;
    logic                 fr_done;
    logic [DATA_BITS-1:0] fr_data;
    err_t                 fr_err;
    logic                 dl_valid;
    logic [DATA_BITS-1:0] dl_data;
    err_t                 dl_err;
    logic                 commit;
    logic [DATA_BITS-1:0] commit_data;
    err_t                 commit_err;

    urs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_in),
        .q_out (rx_s)
    );

    urs_deframer #(
        .DATA_BITS  (DATA_BITS),
        .OVERSAMPLE (OVERSAMPLE),
        .PARITY_EN  (PARITY_EN),
        .PARITY_ODD (PARITY_ODD)
    ) u_deframer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_16x),
        .rx_s  (rx_s),
        .done  (fr_done),
        .data  (fr_data),
        .errs  (fr_err)
    );

    urs_delay #(
        .DATA_BITS (DATA_BITS),
        .DELAY     (FIFO_DELAY)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_16x),
        .in_valid  (fr_done && fifo_mode),
        .in_data   (fr_data),
        .in_err    (fr_err),
        .out_valid (dl_valid),
        .out_data  (dl_data),
        .out_err   (dl_err)
    );

    // Pick the direct or delayed character for the status registers.
    always_comb begin
        commit      = (fr_done && !fifo_mode) || dl_valid;
        commit_data = dl_valid ? dl_data : fr_data;
        commit_err  = dl_valid ? dl_err  : fr_err;
    end

    urs_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_16x),
        .fifo_mode   (fifo_mode),
        .commit      (commit),
        .commit_fifo (dl_valid),
        .commit_data (commit_data),
        .commit_err  (commit_err),
        .rbr_rd      (rbr_rd),
        .lsr_rd      (lsr_rd),
        .rx_data     (rx_data),
        .data_ready  (data_ready),
        .overrun_err (overrun_err),
        .parity_err  (parity_err),
        .framing_err (framing_err),
        .break_det   (break_det),
        .rx_irq      (rx_irq)
    );
endmodule

// File: tb/uart_rx_status_tb.sv
// Directed bench for uart_rx_status. There is one task per scenario. Inputs
// change on the falling clock edge, and outputs are sampled there.
module uart_rx_status_tb;
    localparam int LAT_DIR  = 171;
    localparam int LAT_FIFO = 174;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       fifo = 1'b0;
    logic       rbr_rd = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] rx_data;
    logic       dr, oe, pe, fe, bi, irq;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int t0 = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_rx_status u_dut (
        .clk (clk), .rst_n (rst_n), .tick_16x (1'b1), .rx_in (rx),
        .fifo_mode (fifo), .rbr_rd (rbr_rd), .lsr_rd (lsr_rd),
        .rx_data (rx_data), .data_ready (dr), .overrun_err (oe),
        .parity_err (pe), .framing_err (fe), .break_det (bi), .rx_irq (irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_until(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input bit bad_par, input bit stopv);
        rx = 1'b0;
        repeat (16) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rx = b[k];
            repeat (16) @(negedge clk);
        end
        rx = (^b) ^ bad_par;
        repeat (16) @(negedge clk);
        rx = stopv;
        repeat (16) @(negedge clk);
        rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] b, input bit bad_par, input bit stopv);
        @(negedge clk);
        send_bits(b, bad_par, stopv);
    endtask

    task automatic rd_rbr();
        @(negedge clk); rbr_rd = 1'b1;
        @(negedge clk); rbr_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_lsr();
        @(negedge clk); lsr_rd = 1'b1;
        @(negedge clk); lsr_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        rd_rbr(); rd_rbr(); rd_lsr();
        repeat (3) @(negedge clk);
    endtask

    // Character with timed sampling of data_ready, parity_err and rx_irq.
    task automatic timed_frame(input logic [7:0] b, input bit bad_par, input int lat, input string tag);
        @(negedge clk);
        t0 = cyc;
        fork
            send_bits(b, bad_par, 1'b1);
            begin
                wait_until(t0 + lat - 1);
                chk({tag, " dr early"}, dr, 0);
                chk({tag, " pe early"}, pe, 0);
                @(negedge clk);
                chk({tag, " dr due"}, dr, 1);
                chk({tag, " pe due"}, pe, bad_par);
                chk("R4 irq not yet", irq, 0);
                @(negedge clk);
                chk("R4 irq one tick later", irq, 1);
            end
        join
    endtask

    task automatic t_reset();
        chk("R13 data", rx_data, 0);
        chk("R13 flags", {dr, oe, pe, fe, bi}, 0);
        chk("R13 irq", irq, 0);
    endtask

    task automatic t_direct();
        fifo = 1'b0;
        timed_frame(8'hA5, 1'b0, LAT_DIR, "R3");
        chk("R2 data A5", rx_data, 8'hA5);
        chk("R3 no errors", {oe, fe, bi}, 0);
        @(negedge clk); rbr_rd = 1'b1;
        @(negedge clk);
        chk("R11 dr held during strobe", dr, 1);
        rbr_rd = 1'b0;
        @(negedge clk);
        chk("R11 dr cleared after strobe", dr, 0);
        repeat (2) @(negedge clk);
        chk("R4 irq falls", irq, 0);
    endtask

    task automatic t_parity();
        frame(8'h3C, 1'b1, 1'b1);
        chk("R7 parity flagged", pe, 1);
        chk("R7 data", rx_data, 8'h3C);
        rd_lsr();
        chk("R12 pe cleared", pe, 0);
        chk("R12 dr kept", dr, 1);
        chk("R12 data kept", rx_data, 8'h3C);
        clear_all();
    endtask

    task automatic t_framing();
        frame(8'h81, 1'b0, 1'b0);
        chk("R8 framing", fe, 1);
        chk("R8 no break", bi, 0);
        chk("R8 data", rx_data, 8'h81);
        clear_all();
    endtask

    task automatic t_break();
        @(negedge clk);
        t0 = cyc;
        rx = 1'b0;
        wait_until(t0 + 200);
        chk("R9 break", bi, 1);
        chk("R9 framing with break", fe, 1);
        chk("R9 data zero", rx_data, 0);
        clear_all();
        repeat (200) @(negedge clk);
        chk("R9 no restart while low", dr, 0);
        rx = 1'b1;
        repeat (20) @(negedge clk);
        frame(8'h5A, 1'b0, 1'b1);
        chk("R9 receives after line high", rx_data, 8'h5A);
        chk("R9 dr after recovery", dr, 1);
        clear_all();
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rx = 1'b0;
        repeat (5) @(negedge clk);
        rx = 1'b1;
        repeat (250) @(negedge clk);
        chk("R1 short low ignored", dr, 0);
    endtask

    task automatic t_overrun_direct();
        frame(8'h41, 1'b0, 1'b1);
        chk("R10 no overrun yet", oe, 0);
        frame(8'h42, 1'b0, 1'b1);
        chk("R10 overrun direct", oe, 1);
        chk("R10 newest kept", rx_data, 8'h42);
        clear_all();
    endtask

    task automatic t_fifo_first();
        fifo = 1'b1;
        timed_frame(8'h96, 1'b1, LAT_FIFO, "R5");
        chk("R5 data", rx_data, 8'h96);
        clear_all();
    endtask

    task automatic t_fifo_later();
        frame(8'h11, 1'b0, 1'b1);
        frame(8'h22, 1'b1, 1'b1);
        chk("R6 held error hidden", pe, 0);
        chk("R6 top data", rx_data, 8'h11);
        @(negedge clk); rbr_rd = 1'b1;
        @(negedge clk);
        chk("R6 pe during strobe", pe, 0);
        rbr_rd = 1'b0;
        @(negedge clk);
        chk("R6 pe after strobe", pe, 1);
        chk("R6 promoted data", rx_data, 8'h22);
        chk("R6 dr stays", dr, 1);
        rd_rbr();
        chk("R11 dr cleared fifo", dr, 0);
        clear_all();
    endtask

    task automatic t_fifo_overrun();
        frame(8'h31, 1'b0, 1'b1);
        frame(8'h32, 1'b0, 1'b1);
        chk("R10 no overrun two", oe, 0);
        @(negedge clk);
        t0 = cyc;
        fork
            send_bits(8'h33, 1'b0, 1'b1);
            begin
                wait_until(t0 + LAT_FIFO - 1);
                chk("R5 oe early", oe, 0);
                @(negedge clk);
                chk("R5 oe due", oe, 1);
            end
        join
        chk("R10 top kept", rx_data, 8'h31);
        rd_rbr();
        chk("R10 hold replaced", rx_data, 8'h33);
        clear_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        repeat (10) @(negedge clk);
        t_direct();
        t_parity();
        t_framing();
        t_glitch();
        t_break();
        t_overrun_direct();
        t_fifo_first();
        t_fifo_later();
        t_fifo_overrun();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule